// File: doc/BRIEF.md
# Dithered Output Word Requantizer

This block sits at the end of a 32-bit audio sample path and shortens each sample to one of four output word lengths: 16, 20, 24 or 32 bits. Before the low bits are thrown away, a triangular-distribution dither is added whose size is set by the chosen length, so the rounding error turns into benign noise instead of a signal-correlated artifact. The shortened sample stays left-aligned in a 32-bit word, with its unused low bits cleared.

Samples arrive one at a time on a valid/ready stream with a channel tag (0 = left, 1 = right). Each channel has its own pair of pseudo-random generators, so the noise on the left output is unrelated to the noise on the right one. A bypass input turns the block into a plain register stage that passes every bit untouched. The word length selection and bypass are static configuration inputs. They may only change while no output is pending.

Top module: `word_requant`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With bypass at 1, out_data equals the accepted in_data bit for bit, whatever len_sel holds.
- R3: With bypass at 0 and len_sel = 3 (32-bit output), out_data equals the accepted in_data.
- R4: With bypass at 0 and len_sel = 0, 1 or 2 (16, 20 or 24 bits), the low 16, 12 or 8 bits of out_data are zero.
- R5: With bypass at 0 and len_sel in 0..2, away from full scale, out_data minus (in_data with the dropped bits cleared), taken as signed, is -L, 0 or +L, where L is 2 to the power of the number of dropped bits.
- R6: At 16-bit output, a constant input sitting exactly on the output grid does not always produce the same output, because dither is applied.
- R7: The dithered sum saturates to the signed 32-bit range. Input 0x7FFFFFFF at 16 bits always gives 0x7FFF0000, and input 0x80000000 at 16, 20 or 24 bits always gives 0x80000000.
- R8: When the same input sequence is fed alternately to the left and right channels, the two output sequences differ.
- R9: Reset reloads the generator seeds, so the same stimulus after every reset gives the same output sequence.
- R10: An input accepted at a clock edge appears on out_data with out_valid at 1 and out_chan equal to its tag right after that edge. With no new input and out_ready at 1, out_valid returns to 0 after the next edge.
- R11: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_data and out_chan hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_sel | input | 2 | Output length: 0=16, 1=20, 2=24, 3=32 bits |
| bypass | input | 1 | 1 passes samples unchanged with no dither |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_chan | input | 1 | Channel tag, 0 left, 1 right |
| in_data | input | 32 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_chan | output | 1 | Channel tag of the output sample |
| out_data | output | 32 | Requantized sample, left-aligned |

## Verification
The in-design properties assume that len_sel and bypass only change while out_valid is low. The check on cleared low bits compares the registered output against the configuration that is live at that moment, so it depends on this. The bench therefore waits one idle cycle with out_ready high before every configuration change, which lets the output drain. The saturation properties rely only on the top two input bits, so they hold for any stimulus. The bench keeps its grid-distance samples well away from the two extremes, because the ±L window does not apply where clipping cuts the result.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

  typedef enum logic [1:0] {
    LEN_16 = 2'd0,
    LEN_20 = 2'd1,
    LEN_24 = 2'd2,
    LEN_32 = 2'd3
  } len_e;

  // number of low bits discarded for a given length code
  function automatic int unsigned drop_bits(input logic [1:0] sel, input int unsigned data_w);
    case (sel)
      LEN_16:  return data_w - 16;
      LEN_20:  return data_w - 20;
      LEN_24:  return data_w - 24;
      default: return 0;
    endcase
  endfunction

  // distinct nonzero seeds, one per generator
  function automatic logic [31:0] seed_for(input int unsigned idx);
    case (idx)
      0:       return 32'h1D87_2B41;
      1:       return 32'hA5C3_9E17;
      2:       return 32'h6B2F_04D9;
      default: return 32'hC04E_7713;
    endcase
  endfunction

endpackage

// File: rtl/wrq_lfsr.sv
module wrq_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'h1,
  parameter logic [W-1:0] TAPS = 32'hD000_0001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (step) begin
      state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
    end
  end

  // a zero state would lock the generator and kill the dither
  assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    state != '0);

endmodule

// File: rtl/wrq_tpdf.sv
module wrq_tpdf
  import wrq_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SW    = DATA_W + 2
) (
  input  logic [DATA_W-1:0]     rnd_a,
  input  logic [DATA_W-1:0]     rnd_b,
  input  logic [1:0]            len_sel,
  input  logic                  bypass,
  output logic signed [SW-1:0]  dith,
  output logic [DATA_W-1:0]     keep_mask
);

  int unsigned         drop;
  logic [DATA_W-1:0]   low_mask;

  always_comb begin
    drop      = drop_bits(len_sel, DATA_W);
    low_mask  = bypass ? '0 : ~({DATA_W{1'b1}} << drop);
    keep_mask = ~low_mask;
    // difference of two uniforms: triangular, strictly inside +-1 output LSB
    dith      = $signed({2'b00, rnd_a & low_mask}) - $signed({2'b00, rnd_b & low_mask});
  end

endmodule

// File: rtl/wrq_sat_trunc.sv
module wrq_sat_trunc #(
  parameter int DATA_W = 32,
  localparam int SW    = DATA_W + 2
) (
  input  logic [DATA_W-1:0]     sample,
  input  logic signed [SW-1:0]  dith,
  input  logic [DATA_W-1:0]     keep_mask,
  output logic [DATA_W-1:0]     result
);

  localparam logic signed [SW-1:0] MAX_V = {3'b000, {(DATA_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MIN_V = {3'b111, {(DATA_W-1){1'b0}}};

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] sat;

  always_comb begin
    sum = $signed({{2{sample[DATA_W-1]}}, sample}) + dith;
    if (sum > MAX_V)      sat = MAX_V;
    else if (sum < MIN_V) sat = MIN_V;
    else                  sat = sum;
    result = sat[DATA_W-1:0] & keep_mask;
  end

endmodule

// File: rtl/word_requant.sv
module word_requant
  import wrq_pkg::*;
#(
  parameter int             DATA_W = 32,
  parameter logic [DATA_W-1:0] TAPS = 32'hD000_0001,
  localparam int            NCH    = 2,
  localparam int            NSRC   = 2,
  localparam int            SW     = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        len_sel,
  input  logic              bypass,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_chan,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_chan,
  output logic [DATA_W-1:0] out_data
);

  logic                 accept;
  logic [DATA_W-1:0]    rnd [NCH][NSRC];
  logic signed [SW-1:0] dith;
  logic [DATA_W-1:0]    keep_mask;
  logic [DATA_W-1:0]    shortened;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      wrq_lfsr #(
        .W    (DATA_W),
        .SEED (DATA_W'(seed_for(ch * NSRC + s))),
        .TAPS (TAPS)
      ) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (accept && (in_chan == 1'(ch))),
        .state (rnd[ch][s])
      );
    end
  end

  wrq_tpdf #(.DATA_W(DATA_W)) u_tpdf (
    .rnd_a     (rnd[in_chan][0]),
    .rnd_b     (rnd[in_chan][1]),
    .len_sel   (len_sel),
    .bypass    (bypass),
    .dith      (dith),
    .keep_mask (keep_mask)
  );

  wrq_sat_trunc #(.DATA_W(DATA_W)) u_sat (
    .sample    (in_data),
    .dith      (dith),
    .keep_mask (keep_mask),
    .result    (shortened)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_chan  <= in_chan;
      out_data  <= shortened;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  logic [DATA_W-1:0] live_low_mask;
  assign live_low_mask = ~({DATA_W{1'b1}} << drop_bits(len_sel, DATA_W));

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready);

  assert_bypass_exact_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && bypass) |=> out_data == $past(in_data));

  assert_full_length_exact_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !bypass && len_sel == LEN_32) |=> out_data == $past(in_data));

  assert_low_bits_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !bypass) |-> (out_data & live_low_mask) == '0);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && in_data[DATA_W-1 -: 2] == 2'b01) |=> !out_data[DATA_W-1]);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && in_data[DATA_W-1 -: 2] == 2'b10) |=> out_data[DATA_W-1]);

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid && out_chan == $past(in_chan));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_chan));

  assert_stall_block_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/word_requant_bench.sv
module word_requant_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  len_sel = 2'd0;
  logic        bypass = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_chan = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_chan;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  word_requant u_word_requant (
    .clk(clk), .rst(rst), .len_sel(len_sel), .bypass(bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start and end at a negedge
  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input logic byp, input logic [1:0] len);
    @(posedge clk); @(negedge clk);
    bypass  = byp;
    len_sel = len;
  endtask

  task automatic xfer(input logic ch, input logic [31:0] d,
                      output logic [31:0] q, output logic qc, output logic qv);
    in_valid = 1'b1; in_chan = ch; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    q = out_data; qc = out_chan; qv = out_valid;
  endtask

  // {in[31:0], bypass, len[1:0], chan, expected[31:0]}
  localparam logic [67:0] VEC [8] = '{
    {32'h1234_5678, 1'b1, 2'd0, 1'b0, 32'h1234_5678},
    {32'h8765_4321, 1'b1, 2'd2, 1'b1, 32'h8765_4321},
    {32'hDEAD_BEEF, 1'b0, 2'd3, 1'b0, 32'hDEAD_BEEF},
    {32'h0000_0001, 1'b0, 2'd3, 1'b1, 32'h0000_0001},
    {32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h8000_0000},
    {32'h8000_0000, 1'b0, 2'd1, 1'b1, 32'h8000_0000},
    {32'h8000_0000, 1'b0, 2'd2, 1'b0, 32'h8000_0000},
    {32'h7FFF_FFFF, 1'b1, 2'd0, 1'b1, 32'h7FFF_FFFF}
  };

  logic [31:0] q, q2;
  logic        qc, qv;
  logic [31:0] run_a [8];
  logic [31:0] seq_l [16];
  logic [31:0] seq_r [16];

  initial begin
    do_reset();
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1'b1,  "R1 in_ready after reset",  {31'b0, in_ready}, 32'h1);

    // table walk: R2 bypass, R3 32-bit, R7 negative extreme, R10 tag/valid
    for (int i = 0; i < 8; i++) begin
      set_cfg(VEC[i][35], VEC[i][34:33]);
      xfer(VEC[i][32], VEC[i][67:36], q, qc, qv);
      check(q == VEC[i][31:0], "R2/R3/R7 table data", q, VEC[i][31:0]);
      check(qv && qc == VEC[i][32], "R10 valid and tag", {30'b0, qv, qc}, {31'b0, 1'b1, VEC[i][32]} | 32'h2);
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid drops when idle", {31'b0, out_valid}, 32'h0);

    // R4 and R5: low bits clear and within one output LSB of the grid
    for (int len = 0; len < 3; len++) begin
      set_cfg(1'b0, 2'(len));
      for (int i = 0; i < 12; i++) begin
        logic [31:0] din, lowm, base;
        longint diff, step;
        din  = 32'h0123_4567 + 32'(i) * 32'h0F0F_1234;
        lowm = (len == 0) ? 32'h0000_FFFF : (len == 1) ? 32'h0000_0FFF : 32'h0000_00FF;
        step = longint'(lowm) + 1;
        base = din & ~lowm;
        xfer(1'(i), din, q, qc, qv);
        check((q & lowm) == 0, "R4 low bits clear", q & lowm, 32'h0);
        diff = longint'($signed(q)) - longint'($signed(base));
        check(diff == 0 || diff == step || diff == -step, "R5 grid distance", q, base);
      end
    end

    // R6: dither must move a grid-aligned constant at least once
    set_cfg(1'b0, 2'd0);
    begin
      int moved = 0;
      for (int i = 0; i < 16; i++) begin
        xfer(1'b0, 32'h0001_0000, q, qc, qv);
        if (q != 32'h0001_0000) moved++;
      end
      check(moved > 0, "R6 dither present", 32'(moved), 32'h1);
    end

    // R7: positive extreme at 16 bits
    for (int i = 0; i < 8; i++) begin
      xfer(1'(i), 32'h7FFF_FFFF, q, qc, qv);
      check(q == 32'h7FFF_0000, "R7 positive saturation", q, 32'h7FFF_0000);
    end

    // R8: left and right noise differ
    for (int i = 0; i < 16; i++) begin
      xfer(1'b0, 32'h0000_8000, seq_l[i], qc, qv);
      xfer(1'b1, 32'h0000_8000, seq_r[i], qc, qv);
    end
    begin
      int diffs = 0;
      for (int i = 0; i < 16; i++) if (seq_l[i] != seq_r[i]) diffs++;
      check(diffs > 0, "R8 channels decorrelated", 32'(diffs), 32'h1);
    end

    // R9: reset replays the sequence
    do_reset();
    for (int i = 0; i < 8; i++) xfer(1'(i), 32'h0000_8000, run_a[i], qc, qv);
    xfer(1'b0, 32'h0000_8000, q, qc, qv);
    do_reset();
    for (int i = 0; i < 8; i++) begin
      xfer(1'(i), 32'h0000_8000, q2, qc, qv);
      check(q2 == run_a[i], "R9 seeds reloaded", q2, run_a[i]);
    end

    // R11: back-pressure hold
    set_cfg(1'b1, 2'd0);
    out_ready = 1'b0;
    in_valid = 1'b1; in_chan = 1'b1; in_data = 32'hAAAA_5555;
    @(posedge clk); @(negedge clk);
    in_data = 32'h1111_2222; in_chan = 1'b0;
    check(out_valid && out_data == 32'hAAAA_5555, "R11 first held", out_data, 32'hAAAA_5555);
    check(in_ready == 1'b0, "R11 in_ready low", {31'b0, in_ready}, 32'h0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(out_data == 32'hAAAA_5555 && out_chan == 1'b1, "R11 still held", out_data, 32'hAAAA_5555);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 32'h1111_2222 && out_chan == 1'b0, "R11 next after release", out_data, 32'h1111_2222);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule